// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible control store of a color LCD controller. A host reaches it over a simple 32-bit peripheral bus with separate read and write strobes and a 12-bit byte address; the two low address bits are ignored. It keeps four timing words, the base addresses of the upper and lower panels, an interrupt mask and a control word. From these it continuously decodes the active column count, the row count, the pixel-depth code, the two byte-ordering flags and the active state, so that downstream fetch and timing logic needs no register knowledge of its own.

Interrupt causes come in as a status vector. Each asserted bit latches into a raw status register, which software can read directly or after masking, and can clear by writing ones. A single interrupt line is raised while any unmasked status bit is set. A high address window returns a fixed sequence of identification bytes. A palette window is not stored here: accesses to it are forwarded, with a word index, to a separate palette store whose read data is passed back to the bus.

The bus has no handshake. A write takes effect at the clock edge where the write strobe is high. Read data is combinational and valid in the same cycle as the read strobe; it is zero while the read strobe is low. Only one of the two strobes may be high in a cycle.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every stored register is zero, so reads of word offsets 0 to 9 return zero, active is 0, the depth code is 0, irq is 0, the column count is 16 and the row count is 1.
- R2: Word offsets 0 to 3 (timing), 4 (upper base), 5 (lower base) and 7 (control) store all 32 written bits and read them back; offset 6 (mask) stores its low IRQ_W bits and reads the rest as zero.
- R3: The column count equals (bits 7 to 2 of timing word 0, plus 1) times 16, and follows every write to offset 0 from the next cycle on.
- R4: The row count equals bits 9 to 0 of timing word 1 plus 1, and follows every write to offset 1 from the next cycle on.
- R5: Active is 1 only while control bit 0 and control bit 11 are both 1; the depth code is control bits 3 to 1, the byte-order flag is control bit 9 and the pixel-order flag is control bit 10.
- R6: Every asserted status input bit sets the matching raw bit at the next edge; offset 8 reads raw status, offset 9 reads raw AND mask, and irq is 1 while raw AND mask is non-zero.
- R7: A write to offset 10 clears each raw bit written as 1; a status input bit asserted in the same cycle keeps its raw bit set.
- R8: Byte addresses 0xFE0 to 0xFFF return one identification byte per word, zero-extended, in word order 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Offset 11 reads the upper base and offset 12 reads the lower base.
- R10: Byte addresses 0x200 to 0x3FF raise the palette read or write strobe with index address bits 8 to 2 and the bus write data, return the palette read data, and change no register.
- R11: A read of offset 10, a write to offsets 8, 9, 11, 12 or the identification window, and any access outside the defined offsets reads as zero, changes nothing, and raises err for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as bus_rd |
| irq_src | input | IRQ_W | Interrupt cause vector, one bit per cause |
| irq | output | 1 | OR of masked raw status |
| err | output | 1 | One-cycle flag after an undefined access |
| cols | output | 11 | Active column count |
| rows | output | 11 | Active row count |
| depth | output | 3 | Pixel-depth code |
| active | output | 1 | Enable and power both set |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order within a byte |
| upper_base | output | 32 | Upper panel base address |
| lower_base | output | 32 | Lower panel base address |
| pal_rd | output | 1 | Palette read strobe |
| pal_wr | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |

## Verification
The bench builds the block with IRQ_W set to 4, the default. Four cause bits are enough to hold masked and unmasked bits side by side, so the masked read and the interrupt line are told apart from the raw read, and a clear can hit one bit while a new cause re-sets another in the same cycle. The extreme timing fields (all ones, all zeros, and upper bits outside the decoded fields) reach both ends of the column and row ranges.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int ADDR_W = 12;
  localparam int CNT_W  = 11;

  localparam int CTL_EN  = 0;
  localparam int CTL_BEB = 9;
  localparam int CTL_BEP = 10;
  localparam int CTL_PWR = 11;

  typedef enum logic [3:0] {
    SEL_T0, SEL_T1, SEL_T2, SEL_T3,
    SEL_UPB, SEL_LPB, SEL_MSK, SEL_CTL,
    SEL_RIS, SEL_MIS, SEL_CLR, SEL_UPC, SEL_LPC,
    SEL_PAL, SEL_ID, SEL_NONE
  } sel_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
  import lcdc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  logic [ADDR_W-3:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    if (addr >= 12'hFE0)
      sel = SEL_ID;
    else if (addr[ADDR_W-1:9] == 3'b001)
      sel = SEL_PAL;
    else if (word <= 10'd12)
      sel = sel_t'(word[3:0]);
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/lcdc_status.sv
module lcdc_status #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] src,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wd,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_eff) | src;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
  import lcdc_pkg::*;
(
  input  logic [31:0]      tim0,
  input  logic [31:0]      tim1,
  output logic [CNT_W-1:0] cols,
  output logic [CNT_W-1:0] rows
);
  logic [6:0] col_units;
  assign col_units = {1'b0, tim0[7:2]} + 7'd1;
  assign cols      = {col_units, 4'b0000};
  assign rows      = {1'b0, tim1[9:0]} + 11'd1;
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IRQ_W-1:0]  irq_src,
  output logic              irq,
  output logic              err,
  output logic [10:0]       cols,
  output logic [10:0]       rows,
  output logic [2:0]        depth,
  output logic              active,
  output logic              be_byte,
  output logic              be_pixel,
  output logic [31:0]       upper_base,
  output logic [31:0]       lower_base,
  output logic              pal_rd,
  output logic              pal_wr,
  output logic [6:0]        pal_idx,
  output logic [31:0]       pal_wdata,
  input  logic [31:0]       pal_rdata
);
  localparam int PAD_W = 32 - IRQ_W;

  sel_t sel;
  logic [31:0] tim_q [4];
  logic [31:0] upb_q, lpb_q, ctl_q;
  logic [IRQ_W-1:0] raw_q, mask_q;
  logic rd_ok, wr_ok, err_q;

  lcdc_addr_dec u_dec (.addr(bus_addr), .sel(sel));

  for (genvar gi = 0; gi < 4; gi++) begin : g_tim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             tim_q[gi] <= '0;
      else if (bus_wr && sel == sel_t'(gi))   tim_q[gi] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upb_q <= '0;
      lpb_q <= '0;
      ctl_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_UPB: upb_q <= bus_wdata;
        SEL_LPB: lpb_q <= bus_wdata;
        SEL_CTL: ctl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  lcdc_status #(.IRQ_W(IRQ_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (irq_src),
    .mask_we  (bus_wr && sel == SEL_MSK),
    .mask_wd  (bus_wdata[IRQ_W-1:0]),
    .clr_we   (bus_wr && sel == SEL_CLR),
    .clr_bits (bus_wdata[IRQ_W-1:0]),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  lcdc_geom u_geom (.tim0(tim_q[0]), .tim1(tim_q[1]), .cols(cols), .rows(rows));

  assign depth      = ctl_q[3:1];
  assign be_byte    = ctl_q[CTL_BEB];
  assign be_pixel   = ctl_q[CTL_BEP];
  assign active     = ctl_q[CTL_EN] & ctl_q[CTL_PWR];
  assign upper_base = upb_q;
  assign lower_base = lpb_q;

  assign pal_rd    = bus_rd && sel == SEL_PAL;
  assign pal_wr    = bus_wr && sel == SEL_PAL;
  assign pal_idx   = bus_addr[8:2];
  assign pal_wdata = bus_wdata;

  assign rd_ok = (sel != SEL_NONE) && (sel != SEL_CLR);
  assign wr_ok = (sel <= SEL_CTL) || (sel == SEL_CLR) || (sel == SEL_PAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (bus_rd && !rd_ok) || (bus_wr && !wr_ok);
  end
  assign err = err_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_T0:  bus_rdata = tim_q[0];
        SEL_T1:  bus_rdata = tim_q[1];
        SEL_T2:  bus_rdata = tim_q[2];
        SEL_T3:  bus_rdata = tim_q[3];
        SEL_UPB, SEL_UPC: bus_rdata = upb_q;
        SEL_LPB, SEL_LPC: bus_rdata = lpb_q;
        SEL_MSK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
        SEL_CTL: bus_rdata = ctl_q;
        SEL_RIS: bus_rdata = {{PAD_W{1'b0}}, raw_q};
        SEL_MIS: bus_rdata = {{PAD_W{1'b0}}, raw_q & mask_q};
        SEL_ID:  bus_rdata = {24'h0, id_byte(bus_addr[4:2])};
        SEL_PAL: bus_rdata = pal_rdata;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic [IRQ_W-1:0] irq_src,
  input logic [IRQ_W-1:0] mask_q,
  input logic             irq,
  input logic             err,
  input logic [10:0]      cols,
  input logic [10:0]      rows,
  input logic             active,
  input logic             pal_wr
);
  assert_cols_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd0) |=> (cols == {($past(bus_wdata[7:2]) + 7'd1), 4'b0000}));

  assert_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd1) |=> (rows == $past(bus_wdata[9:0]) + 11'd1));

  assert_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd7) |=> (active == ($past(bus_wdata[0]) && $past(bus_wdata[11]))));

  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(irq_src & mask_q)) && !(bus_wr && bus_addr[11:2] == 10'd6)) |=> irq);

  assert_pal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr |-> (bus_wr && bus_addr[11:9] == 3'b001));

  assert_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(bus_rd || bus_wr));
endmodule

bind lcdc_regbank lcdc_regbank_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq_src(irq_src),
  .mask_q(mask_q), .irq(irq), .err(err), .cols(cols), .rows(rows),
  .active(active), .pal_wr(pal_wr)
);

// File: tb/tb_lcdc_regbank.sv
module tb_lcdc_regbank;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [IW-1:0] irq_src = '0;
  logic irq, err, active, be_byte, be_pixel, pal_rd, pal_wr;
  logic [10:0] cols, rows;
  logic [2:0] depth;
  logic [31:0] upper_base, lower_base, pal_wdata, pal_rdata;
  logic [6:0] pal_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign pal_rdata = 32'hC0DE0000 | {25'h0, pal_idx};

  lcdc_regbank #(.IRQ_W(IW)) dut (.*);

  // behavioural reference
  logic [31:0] m_tim [4];
  logic [31:0] m_upb, m_lpb, m_ctl;
  logic [IW-1:0] m_msk, m_raw;
  logic m_err;

  function automatic bit in_pal(input logic [11:0] a);
    return a >= 12'h200 && a < 12'h400;
  endfunction

  function automatic bit wr_legal(input logic [11:0] a);
    int w = int'(a) / 4;
    if (a >= 12'hFE0) return 0;
    if (in_pal(a)) return 1;
    return (w <= 7) || (w == 10);
  endfunction

  function automatic bit rd_legal(input logic [11:0] a);
    int w = int'(a) / 4;
    if (a >= 12'hFE0 || in_pal(a)) return 1;
    return (w <= 9) || (w == 11) || (w == 12);
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [7:0] ids [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    int w = int'(a) / 4;
    if (a >= 12'hFE0) return {24'h0, ids[w % 8]};
    if (in_pal(a)) return 32'hC0DE0000 | (int'(a) % 512) / 4;
    case (w)
      0, 1, 2, 3: return m_tim[w];
      4, 11:      return m_upb;
      5, 12:      return m_lpb;
      6:          return {28'h0, m_msk};
      7:          return m_ctl;
      8:          return {28'h0, m_raw};
      9:          return {28'h0, m_raw & m_msk};
      default:    return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_tim[i] <= '0;
      m_upb <= '0; m_lpb <= '0; m_ctl <= '0;
      m_msk <= '0; m_raw <= '0; m_err <= 0;
    end else begin
      logic [IW-1:0] clr;
      int w;
      w = int'(bus_addr) / 4;
      clr = (bus_wr && w == 10) ? bus_wdata[IW-1:0] : '0;
      m_err <= (bus_rd && !rd_legal(bus_addr)) || (bus_wr && !wr_legal(bus_addr));
      if (bus_wr && wr_legal(bus_addr) && !in_pal(bus_addr)) begin
        case (w)
          0, 1, 2, 3: m_tim[w] <= bus_wdata;
          4: m_upb <= bus_wdata;
          5: m_lpb <= bus_wdata;
          6: m_msk <= bus_wdata[IW-1:0];
          7: m_ctl <= bus_wdata;
          default: ;
        endcase
      end
      m_raw <= (m_raw & ~clr) | irq_src;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cols == 11'((int'(m_tim[0][7:2]) + 1) * 16), "R3 cols", 32'(cols), 32'((int'(m_tim[0][7:2]) + 1) * 16));
      chk(rows == 11'(int'(m_tim[1][9:0]) + 1), "R4 rows", 32'(rows), 32'(int'(m_tim[1][9:0]) + 1));
      chk(active == (m_ctl[0] && m_ctl[11]), "R5 active", 32'(active), 32'(m_ctl[0] && m_ctl[11]));
      chk({be_pixel, be_byte, depth} == {m_ctl[10], m_ctl[9], m_ctl[3:1]}, "R5 depth/order",
          32'({be_pixel, be_byte, depth}), 32'({m_ctl[10], m_ctl[9], m_ctl[3:1]}));
      chk(irq == |(m_raw & m_msk), "R6 irq", 32'(irq), 32'(|(m_raw & m_msk)));
      chk(err == m_err, "R11 err", 32'(err), 32'(m_err));
      chk(upper_base == m_upb && lower_base == m_lpb, "R2 bases", upper_base ^ lower_base, m_upb ^ m_lpb);
    end
  end

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input logic [IW-1:0] s = '0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0; irq_src = s;
    #2;
    if (in_pal(a)) begin
      chk(pal_wr && !pal_rd && pal_idx == a[8:2] && pal_wdata == d, "R10 palette write", {pal_wr, pal_rd, pal_idx}, {2'b10, a[8:2]});
    end else begin
      chk(!pal_wr, "R10 no palette strobe", 32'(pal_wr), 32'h0);
    end
  endtask

  task automatic do_rd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1; bus_wr = 0; irq_src = '0;
    #2;
    e = mread(a);
    chk(bus_rdata == e, tag, bus_rdata, e);
    if (in_pal(a))
      chk(pal_rd && pal_idx == a[8:2], "R10 palette read strobe", {pal_rd, pal_idx}, {1'b1, a[8:2]});
  endtask

  task automatic do_idle(input int n, input logic [IW-1:0] s = '0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; irq_src = (i == 0) ? s : '0;
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk);
    chk(cols == 11'd16 && rows == 11'd1 && !active && depth == 0 && !irq, "R1 reset outputs",
        {cols, rows, 3'(depth), 1'(active), 1'(irq)}, {11'd16, 11'd1, 5'd0});
    for (int w = 0; w < 10; w++) do_rd(12'(w * 4), "R1 reset read zero");

    // R3 column decode
    do_wr(12'h000, 32'h0000_00FC); do_idle(1);
    chk(cols == 11'd1024, "R3 widest cols", 32'(cols), 32'd1024);
    do_wr(12'h000, 32'hFFFF_FF2B); do_idle(1);
    chk(cols == 11'd176, "R3 cols ignores other bits", 32'(cols), 32'd176);
    do_rd(12'h000, "R2 timing0 readback");
    // R4 row decode
    do_wr(12'h004, 32'h0000_03FF); do_idle(1);
    chk(rows == 11'd1024, "R4 tallest rows", 32'(rows), 32'd1024);
    do_wr(12'h004, 32'hFFFF_F4EF); do_idle(1);
    chk(rows == 11'd240, "R4 rows ignores other bits", 32'(rows), 32'd240);
    do_rd(12'h004, "R2 timing1 readback");
    // R2 remaining storage, R9 current address
    do_wr(12'h008, 32'hA5A5_1234);
    do_wr(12'h00C, 32'h5A5A_8765);
    do_wr(12'h010, 32'h8010_0000);
    do_wr(12'h014, 32'h0020_0400);
    do_rd(12'h008, "R2 timing2 readback");
    do_rd(12'h00C, "R2 timing3 readback");
    do_rd(12'h010, "R2 upper base readback");
    do_rd(12'h014, "R2 lower base readback");
    do_rd(12'h02C, "R9 upper current");
    do_rd(12'h030, "R9 lower current");

    // R5 enable needs both bits
    do_wr(12'h01C, 32'h0000_0001); do_idle(1);
    chk(!active, "R5 enable alone", 32'(active), 32'h0);
    do_wr(12'h01C, 32'h0000_0800); do_idle(1);
    chk(!active, "R5 power alone", 32'(active), 32'h0);
    do_wr(12'h01C, 32'h0000_0E0B); do_idle(1);
    chk(active && depth == 3'd5 && be_byte && be_pixel, "R5 decoded control",
        {active, depth, be_byte, be_pixel}, {1'b1, 3'd5, 2'b11});
    do_rd(12'h01C, "R2 control readback");

    // R6 status and mask
    do_wr(12'h018, 32'hFFFF_FFF5);
    do_rd(12'h018, "R2 mask keeps low bits");
    do_idle(2, 4'b0011);
    do_rd(12'h020, "R6 raw status");
    do_rd(12'h024, "R6 masked status");
    chk(irq, "R6 irq raised", 32'(irq), 32'h1);
    // R7 clear and priority
    do_wr(12'h028, 32'h0000_0001); do_idle(1);
    chk(!irq, "R7 clear drops irq", 32'(irq), 32'h0);
    do_rd(12'h020, "R7 raw after clear");
    do_wr(12'h028, 32'h0000_0002, 4'b0010); do_idle(1);
    do_rd(12'h020, "R7 set wins over clear");
    do_wr(12'h028, 32'h0000_000F); do_idle(1);
    do_rd(12'h020, "R7 full clear");

    // R8 identification window
    for (int i = 0; i < 8; i++) do_rd(12'(12'hFE0 + i * 4), "R8 id byte");

    // R10 palette window
    do_wr(12'h200, 32'h1111_2222);
    do_wr(12'h3FC, 32'h3333_4444);
    do_rd(12'h2A8, "R10 palette read data");
    do_rd(12'h000, "R10 registers untouched");
    do_rd(12'h01C, "R10 control untouched");

    // R11 undefined accesses
    do_rd(12'h034, "R11 undefined read zero");
    do_rd(12'h028, "R11 clear reads zero");
    do_wr(12'h020, 32'hFFFF_FFFF);
    do_wr(12'h02C, 32'h1234_5678);
    do_wr(12'hFE0, 32'hFFFF_FFFF);
    do_wr(12'h400, 32'hDEAD_BEEF);
    do_idle(1);
    chk(err, "R11 err after bad write", 32'(err), 32'h1);
    do_idle(1);
    chk(!err, "R11 err single cycle", 32'(err), 32'h0);
    do_rd(12'h020, "R11 raw unchanged");
    do_rd(12'h010, "R11 base unchanged");
    do_rd(12'hFE0, "R11 id unchanged");
    do_idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule